// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command-register front end of a NOR-style flash device model. It watches the bus write cycles. Each write is scored against the expected multi-cycle unlock-and-command sequences. It can load a 16-bit burst configuration register or expose that register for readback. It tracks which read mode the device is in and falls back to array read whenever a sequence goes wrong.

Addresses are captured when the active-low address-valid strobe rises. Data is taken when the active-low write-enable strobe rises. The strobes are sampled on the system clock, and each rising edge is detected between two consecutive clock samples.

The memory array and the program and erase engines are outside the block. A busy input and an error input stand in for them.

Top module: `flash_cmd_decoder`

## Requirements
- R1: On reset (`rst_ni` low), `mode_o` is 0 (array read), the configuration register holds `CFG_RESET` (default 16'h1C42), `sync_mode_o` is 0 and `rdata_o` is 0.
- R2: The address of a write is the value on `addr_i` at the clock edge where `adv_ni` is first seen high after being low. Later changes to `addr_i` do not alter it.
- R3: Write data is the value on `wdata_i` at the clock edge where `we_ni` is first seen high after being low. Values driven earlier in the low phase are not used.
- R4: A write of AAh at address 555h enters state 1. A following write of 55h at 2AAh enters state 2. Then D0h at 555h enters state 3. Then any word at address 000h loads the configuration register and enters the pending state 5. The register changes in no other way.
- R5: A write of C6h at 555h in state 2 enters state 4. In state 4, with `oe_ni` low and the last captured address 000h, `rdata_o` shows the configuration register. In every other case, `rdata_o` is 0.
- R6: A write whose address or low data byte does not match the expected step in states 1, 2 or 3 returns `mode_o` to 0 without loading the register. In state 0, any write other than AAh at 555h keeps state 0.
- R7: In states 4 and 5, writes other than F0h (low byte) are ignored. F0h at any address returns to state 0.
- R8: With `busy_i` high, a D0h command in state 2 or a word write in state 3 returns to state 0 and leaves the register unchanged.
- R9: When `busy_i` and `err_i` are both high on a clock edge, `mode_o` becomes 7. It stays 7 until an F0h write arrives while that condition is absent.
- R10: A write of 90h at 555h in state 2 enters autoselect, state 6. Only F0h leaves it.
- R11: `sync_mode_o` equals bit `SYNC_BIT` (default 15) of the configuration register.
- R12: An F0h write in state 1 or 2 returns to state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_ni | input | 1 | Active-low address-valid strobe |
| we_ni | input | 1 | Active-low write-enable strobe |
| oe_ni | input | 1 | Active-low output enable |
| addr_i | input | AW | Bus address |
| wdata_i | input | DW | Bus write data |
| busy_i | input | 1 | Embedded operation in progress |
| err_i | input | 1 | Embedded operation error status |
| rdata_o | output | DW | Configuration readback, 0 otherwise |
| sync_mode_o | output | 1 | Synchronous mode select from configuration |
| mode_o | output | 3 | Decoder state: 0 array, 1/2 unlock steps, 3 load, 4 config read, 5 pending, 6 autoselect, 7 fault |

## Verification
The bench builds the block with its defaults: a 12-bit address, a 16-bit data word, a reset value of 1C42h and the sync bit at 15. With these values, the exact command addresses 555h, 2AAh and 000h are used. A register word with bit 15 set then shows up directly on `sync_mode_o`. The reset value also differs in both bytes from every word the bench loads, so a missed or spurious load is visible in a readback.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    M_ARRAY    = 3'd0,
    M_UNLK1    = 3'd1,
    M_UNLK2    = 3'd2,
    M_CFG_LOAD = 3'd3,
    M_CFG_READ = 3'd4,
    M_CFG_PEND = 3'd5,
    M_AUTOSEL  = 3'd6,
    M_FAULT    = 3'd7
  } mode_e;

  localparam int unsigned KEY_AW = 12;

  localparam logic [KEY_AW-1:0] ADR_KEY1 = 12'h555;
  localparam logic [KEY_AW-1:0] ADR_KEY2 = 12'h2AA;
  localparam logic [KEY_AW-1:0] ADR_CFG  = 12'h000;

  localparam logic [7:0] CMD_KEY1    = 8'hAA;
  localparam logic [7:0] CMD_KEY2    = 8'h55;
  localparam logic [7:0] CMD_CFG_WR  = 8'hD0;
  localparam logic [7:0] CMD_CFG_RD  = 8'hC6;
  localparam logic [7:0] CMD_AUTOSEL = 8'h90;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic rise_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b1;
    else         q <= strobe_ni;
  end

  assign rise_o = strobe_ni & ~q;
endmodule

// File: rtl/bus_capture.sv
module bus_capture #(
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_q_o,
  output logic          wr_evt_o
);
  logic adv_rise;

  strobe_rise u_adv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_ni(adv_ni),
    .rise_o   (adv_rise)
  );

  strobe_rise u_we (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_ni(we_ni),
    .rise_o   (wr_evt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q_o <= '0;
    else if (adv_rise) addr_q_o <= addr_i;
  end
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import fcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_evt_i,
  input  logic [KEY_AW-1:0] wr_addr_i,
  input  logic [7:0]        wr_cmd_i,
  input  logic              busy_i,
  input  logic              err_i,
  output mode_e             mode_o,
  output logic              load_o
);
  mode_e mode_q, mode_d;
  logic  at_key1, is_rst;

  assign at_key1 = (wr_addr_i == ADR_KEY1);
  assign is_rst  = (wr_cmd_i == CMD_RESET);

  always_comb begin
    mode_d = mode_q;
    load_o = 1'b0;
    if (busy_i && err_i) begin
      mode_d = M_FAULT;
    end else if (wr_evt_i) begin
      unique case (mode_q)
        M_ARRAY: mode_d = (at_key1 && wr_cmd_i == CMD_KEY1) ? M_UNLK1 : M_ARRAY;
        M_UNLK1: mode_d = (wr_addr_i == ADR_KEY2 && wr_cmd_i == CMD_KEY2) ? M_UNLK2 : M_ARRAY;
        M_UNLK2: begin
          mode_d = M_ARRAY;
          if (at_key1) begin
            unique case (wr_cmd_i)
              CMD_CFG_WR:  mode_d = busy_i ? M_ARRAY : M_CFG_LOAD;
              CMD_CFG_RD:  mode_d = M_CFG_READ;
              CMD_AUTOSEL: mode_d = M_AUTOSEL;
              default:     mode_d = M_ARRAY;
            endcase
          end
        end
        M_CFG_LOAD: begin
          // any word at the config address is data, even F0h
          if (wr_addr_i == ADR_CFG && !busy_i) begin
            load_o = 1'b1;
            mode_d = M_CFG_PEND;
          end else begin
            mode_d = M_ARRAY;
          end
        end
        default: mode_d = is_rst ? M_ARRAY : mode_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= M_ARRAY;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/cfg_reg.sv
module cfg_reg #(
  parameter int unsigned      DW        = 16,
  parameter logic [DW-1:0]    RESET_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RESET_VAL;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int unsigned   AW        = 12,
  parameter int unsigned   DW        = 16,
  parameter logic [DW-1:0] CFG_RESET = 16'h1C42,
  parameter int unsigned   SYNC_BIT  = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          err_i,
  output logic [DW-1:0] rdata_o,
  output logic          sync_mode_o,
  output logic [2:0]    mode_o
);
  logic [AW-1:0] addr_q;
  logic          wr_evt;
  logic          cfg_load;
  logic [DW-1:0] cfg_q;
  mode_e         mode;

  bus_capture #(.AW(AW)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_ni  (adv_ni),
    .we_ni   (we_ni),
    .addr_i  (addr_i),
    .addr_q_o(addr_q),
    .wr_evt_o(wr_evt)
  );

  cmd_seq_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_evt_i (wr_evt),
    .wr_addr_i(addr_q[KEY_AW-1:0]),
    .wr_cmd_i (wdata_i[7:0]),
    .busy_i   (busy_i),
    .err_i    (err_i),
    .mode_o   (mode),
    .load_o   (cfg_load)
  );

  cfg_reg #(.DW(DW), .RESET_VAL(CFG_RESET)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cfg_load),
    .d_i   (wdata_i),
    .q_o   (cfg_q)
  );

  assign rdata_o     = (!oe_ni && mode == M_CFG_READ && addr_q[KEY_AW-1:0] == ADR_CFG) ? cfg_q : '0;
  assign sync_mode_o = cfg_q[SYNC_BIT];
  assign mode_o      = mode;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_ni,
  input logic [7:0]    cmd_i,
  input logic          busy_i,
  input logic          err_i,
  input logic [2:0]    mode_o,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] cfg_q
);
  logic we_q;
  logic wr_evt;
  logic rst_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= we_ni;
  end

  assign wr_evt = we_ni & ~we_q;
  assign rst_wr = wr_evt && cmd_i == 8'hF0;

  AST_CFG_ONLY_FROM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> ($past(mode_o) == 3'd3 && !$past(busy_i))) else $error("cfg changed outside load"); // R4

  AST_RDATA_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 3'd4) |-> (rdata_o == '0)) else $error("rdata outside config read"); // R5

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 3'd4 || mode_o == 3'd5) && !(busy_i && err_i) && !rst_wr) |=> $stable(mode_o)) else $error("pending left early"); // R7

  AST_BUSY_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cfg_q)) else $error("cfg loaded while busy"); // R8

  AST_FAULT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && err_i) |=> (mode_o == 3'd7)) else $error("fault not entered"); // R9

  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd7 && !rst_wr) |=> (mode_o == 3'd7)) else $error("fault left without reset"); // R9

  AST_AUTOSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd6 && !(busy_i && err_i) && !rst_wr) |=> (mode_o == 3'd6)) else $error("autoselect left early"); // R10
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_ni  (we_ni),
  .cmd_i  (wdata_i[7:0]),
  .busy_i (busy_i),
  .err_i  (err_i),
  .mode_o (mode_o),
  .rdata_o(rdata_o),
  .cfg_q  (cfg_q)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        busy = 1'b0, err = 1'b0;
  logic [15:0] rdata;
  logic        sync_mode;
  logic [2:0]  mode;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .adv_ni(adv_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .wdata_i(wdata), .busy_i(busy), .err_i(err),
    .rdata_o(rdata), .sync_mode_o(sync_mode), .mode_o(mode)
  );

  // {address, data, expected mode}
  localparam int NV = 25;
  localparam logic [30:0] VEC [NV] = '{
    {12'h555, 16'h00AA, 3'd1}, {12'h2AA, 16'h0055, 3'd2}, {12'h555, 16'h00D0, 3'd3},
    {12'h000, 16'h1234, 3'd5}, {12'h555, 16'h00AA, 3'd5}, {12'h123, 16'h00F0, 3'd0},
    {12'h555, 16'h00AA, 3'd1}, {12'h2AA, 16'h0054, 3'd0},
    {12'h555, 16'h00AA, 3'd1}, {12'h2AA, 16'h0055, 3'd2}, {12'h555, 16'h00C7, 3'd0},
    {12'h555, 16'h00AA, 3'd1}, {12'h2AA, 16'h0055, 3'd2}, {12'h555, 16'h00D0, 3'd3},
    {12'h004, 16'hABCD, 3'd0}, {12'h555, 16'h00AB, 3'd0},
    {12'h555, 16'h00AA, 3'd1}, {12'h555, 16'h0055, 3'd0},
    {12'h555, 16'h00AA, 3'd1}, {12'h2AA, 16'h0055, 3'd2}, {12'h555, 16'h0090, 3'd6},
    {12'h555, 16'h00AA, 3'd6}, {12'h000, 16'h00F0, 3'd0},
    {12'h555, 16'h00AA, 3'd1}, {12'h0F0, 16'h00F0, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // address held only through the adv rise, early data is wrong on purpose
  task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; adv_n = 1'b0;
    @(negedge clk); adv_n = 1'b1;
    @(negedge clk); addr = 12'hFFF; we_n = 1'b0; wdata = ~d;
    @(negedge clk); wdata = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); wdata = 16'h0;
  endtask

  task automatic addr_only(input logic [11:0] a);
    @(negedge clk); addr = a; adv_n = 1'b0;
    @(negedge clk); adv_n = 1'b1;
    @(negedge clk); addr = 12'hFFF;
  endtask

  task automatic unlock();
    bus_write(12'h555, 16'h00AA);
    bus_write(12'h2AA, 16'h0055);
  endtask

  task automatic read_cfg(input string req, input logic [15:0] exp);
    unlock();
    bus_write(12'h555, 16'h00C6);
    chk({req, " read mode"}, 32'(mode), 32'd4);
    addr_only(12'h000);
    oe_n = 1'b0;
    @(negedge clk);
    chk({req, " readback"}, 32'(rdata), 32'(exp));
    oe_n = 1'b1;
    bus_write(12'h000, 16'h00F0);
    chk({req, " exit read"}, 32'(mode), 32'd0);
  endtask

  task automatic write_cfg(input logic [15:0] w);
    unlock();
    bus_write(12'h555, 16'h00D0);
    bus_write(12'h000, w);
    bus_write(12'h000, 16'h00F0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset mode", 32'(mode), 32'd0);
    chk("R1 reset sync", 32'(sync_mode), 32'd0);
    chk("R1 reset rdata", 32'(rdata), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_cfg("R1 default", 16'h1C42);

    // R2 R3 R4 R6 R7 R10 R12 table walk
    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][30:19], VEC[i][18:3]);
      chk($sformatf("R4/R6/R7/R10/R12 vec %0d", i), 32'(mode), 32'(VEC[i][2:0]));
    end
    read_cfg("R4 R2 R3 loaded", 16'h1234);

    // R5 readback only at address 000
    unlock();
    bus_write(12'h555, 16'h00C6);
    addr_only(12'h555);
    oe_n = 1'b0;
    @(negedge clk);
    chk("R5 wrong addr rdata", 32'(rdata), 32'd0);
    oe_n = 1'b1;
    @(negedge clk);
    addr_only(12'h000);
    chk("R5 oe high rdata", 32'(rdata), 32'd0);
    bus_write(12'h000, 16'h00F0);

    // R11
    write_cfg(16'h8001);
    chk("R11 sync set", 32'(sync_mode), 32'd1);
    chk("R7 after reset cmd", 32'(mode), 32'd0);

    // R8 busy at D0 step
    unlock();
    busy = 1'b1;
    bus_write(12'h555, 16'h00D0);
    chk("R8 busy D0 mode", 32'(mode), 32'd0);
    busy = 1'b0;
    // R8 busy at word step
    unlock();
    bus_write(12'h555, 16'h00D0);
    chk("R8 load step mode", 32'(mode), 32'd3);
    busy = 1'b1;
    bus_write(12'h000, 16'h0F0F);
    chk("R8 busy word mode", 32'(mode), 32'd0);
    busy = 1'b0;
    chk("R8 sync kept", 32'(sync_mode), 32'd1);
    read_cfg("R8 cfg kept", 16'h8001);

    // R9 fault
    @(negedge clk); busy = 1'b1; err = 1'b1;
    @(negedge clk);
    chk("R9 fault entry", 32'(mode), 32'd7);
    busy = 1'b0; err = 1'b0;
    bus_write(12'h555, 16'h00AA);
    chk("R9 fault hold", 32'(mode), 32'd7);
    bus_write(12'h000, 16'h00F0);
    chk("R9 fault exit", 32'(mode), 32'd0);

    // R1 reset mid-sequence
    unlock();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 async reset mode", 32'(mode), 32'd0);
    chk("R1 async reset sync", 32'(sync_mode), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_cfg("R1 reset value", 16'h1C42);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule